// File: doc/BRIEF.md
# Serial Line Low-Time Timer for Baud Estimation

This block times how long an incoming serial line stays low so that software can estimate the bit rate of a remote sender. Software sets an arm bit. The block then watches the already-synchronized receive line for a falling edge. From that edge it counts clock cycles until the line goes high again. It then stores the count, raises an interrupt flag and clears the arm bit by itself. Turning the count into a bit rate is left to software.

If the arm bit is cleared while a count is running, the count is not aborted. The block stays in the counting state and raises its interrupt on every later rising edge. This continues until software sets the arm bit again. The next rising edge then ends the measurement normally, and the stored count covers the whole time since the original falling edge. If the arm bit is cleared while no count is running, the block goes back to idle.

The interrupt flag stays set until software clears it with a one-cycle write-one pulse.

Top module: `abr_edge_timer`

## Requirements
- R1: After reset, arm_o, busy_o, irq_o and count_o are all 0.
- R2: A cycle with arm_we=1 loads arm_wd into arm_o on the next edge. While arm_o=1 and busy_o=0, a falling edge on rx_i (sampled 1, then sampled 0) sets busy_o on that clock edge.
- R3: While busy_o=1 and arm_o=1, a rising edge on rx_i (sampled 0, then sampled 1) ends the measurement on that clock edge. After it, busy_o=0, arm_o=0, irq_o=1, and count_o equals the number of clock edges at which rx_i was sampled low, from the falling edge up to the rising edge.
- R4: The running count restarts at each new falling edge that starts a measurement. A second measurement reports only its own length, with nothing left over from the first.
- R5: The count saturates at 2**CNT_W-1 and does not wrap.
- R6: While busy_o=1 and arm_o=0, every rising edge on rx_i sets irq_o. busy_o stays 1 and count_o keeps its previous value.
- R7: Setting arm_o again during that condition makes the next rising edge end the measurement as in R3. The reported count runs from the original falling edge, and falling edges seen while busy do not restart it.
- R8: While busy_o=0, a falling edge on rx_i with arm_o=0 is ignored. This includes the case where the arm bit was set and then cleared before the edge: busy_o stays 0 and irq_o stays 0.
- R9: A cycle with irq_clr=1 clears irq_o on the next edge. If an interrupt event occurs in the same cycle, irq_o is set instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Receive line, already synchronized to clk |
| arm_we | input | 1 | Write strobe for the arm bit |
| arm_wd | input | 1 | Value written to the arm bit |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| arm_o | output | 1 | Current arm bit |
| busy_o | output | 1 | Status: 1 while counting, 0 while idle or waiting for a falling edge |
| count_o | output | CNT_W | Stored low-time count from the last completed measurement |
| irq_o | output | 1 | Interrupt flag |

## Verification
The timer is driven with low pulses of several lengths, and the expected count is taken from the bench's own count of clock edges. A wrong count points to an off-by-one at the start or end edge. Two measurements of different lengths, run back to back, show whether the counter restarts. A pulse longer than the counter's range checks saturation. A sequence that clears the arm bit mid-count and then gives several pulses separates the abnormal repeated-interrupt mode from normal completion. Re-arming at the end checks that the count spans the whole period from the original falling edge. Falling edges while disarmed, and an interrupt clear that coincides with a completion, cover the cases where an input must be ignored or must lose to another.

// File: rtl/abr_pkg.sv
package abr_pkg;
  // Saturating increment used by the low-time counter.
  function automatic logic [31:0] sat_inc32(input logic [31:0] v, input logic [31:0] max_v);
    return (v >= max_v) ? max_v : v + 32'd1;
  endfunction
endpackage

// File: rtl/abr_edge_detect.sv
module abr_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  logic rx_q;

  // The line idles high, so the previous sample resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
  assign rise_o = ~rx_q & rx_i;
endmodule

// File: rtl/abr_ctrl.sv
module abr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic rise_i,
  input  logic arm_we,
  input  logic arm_wd,
  input  logic irq_clr,
  output logic arm_q,
  output logic busy_q,
  output logic irq_q,
  output logic begin_ev,
  output logic done_ev,
  output logic abn_ev
);
  assign begin_ev = ~busy_q & arm_q & fall_i;
  assign done_ev  = busy_q & arm_q & rise_i;
  assign abn_ev   = busy_q & ~arm_q & rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // Self-clear on normal completion wins over a software write.
      if (done_ev)     arm_q <= 1'b0;
      else if (arm_we) arm_q <= arm_wd;

      if (begin_ev)     busy_q <= 1'b1;
      else if (done_ev) busy_q <= 1'b0;

      if (done_ev || abn_ev) irq_q <= 1'b1;
      else if (irq_clr)      irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/abr_counter.sv
module abr_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_ev,
  input  logic             busy_i,
  input  logic             done_ev,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] lat_o
);
  import abr_pkg::*;
  localparam logic [31:0] MAX_V = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] nxt;
  assign nxt = CNT_W'(sat_inc32(32'(run_o), MAX_V));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o <= '0;
      lat_o <= '0;
    end else begin
      if (begin_ev)    run_o <= '0;
      else if (busy_i) run_o <= nxt;
      if (done_ev)     lat_o <= nxt;
    end
  end
endmodule

// File: rtl/abr_edge_timer.sv
module abr_edge_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             arm_we,
  input  logic             arm_wd,
  input  logic             irq_clr,
  output logic             arm_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic fall_ev, rise_ev, begin_ev, done_ev, abn_ev;
  logic [CNT_W-1:0] run_cnt;

  abr_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .fall_o(fall_ev), .rise_o(rise_ev)
  );

  abr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_ev), .rise_i(rise_ev),
    .arm_we(arm_we), .arm_wd(arm_wd), .irq_clr(irq_clr),
    .arm_q(arm_o), .busy_q(busy_o), .irq_q(irq_o),
    .begin_ev(begin_ev), .done_ev(done_ev), .abn_ev(abn_ev)
  );

  abr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .begin_ev(begin_ev), .busy_i(busy_o),
    .done_ev(done_ev), .run_o(run_cnt), .lat_o(count_o)
  );
endmodule

// File: rtl/abr_edge_timer_chk.sv
module abr_edge_timer_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_ev,
  input logic             rise_ev,
  input logic             irq_clr,
  input logic             arm_o,
  input logic             busy_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_ARM_TO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && arm_o && fall_ev) |=> busy_o); // R2
  AST_NORMAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && arm_o && rise_ev) |=> (!busy_o && !arm_o && irq_o)); // R3
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_cnt == CMAX) |=> (run_cnt == CMAX || run_cnt == '0)); // R5
  AST_ABNORMAL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !arm_o && rise_ev) |=> (busy_o && irq_o)); // R6
  AST_ABNORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !arm_o) |=> $stable(count_o)); // R6
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !arm_o) |=> !busy_o); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !(busy_o && rise_ev)) |=> !irq_o); // R9
endmodule

bind abr_edge_timer abr_edge_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
  .irq_clr(irq_clr), .arm_o(arm_o), .busy_o(busy_o), .irq_o(irq_o),
  .count_o(count_o), .run_cnt(run_cnt)
);

// File: tb/abr_edge_timer_test.sv
module abr_edge_timer_test;
  localparam int W = 6;
  localparam int CMAX = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, rx_i = 1'b1;
  logic arm_we = 1'b0, arm_wd = 1'b0, irq_clr = 1'b0;
  logic arm_o, busy_o, irq_o;
  logic [W-1:0] count_o;
  int total = 0, bad = 0, tick = 0, t0 = 0, t1 = 0;

  abr_edge_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .arm_we(arm_we), .arm_wd(arm_wd),
    .irq_clr(irq_clr), .arm_o(arm_o), .busy_o(busy_o), .count_o(count_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    rx_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_now(); t0 = tick; rx_i = 1'b0; endtask
  task automatic rise_now(); t1 = tick; rx_i = 1'b1; endtask

  task automatic wr_arm(logic d);
    arm_we = 1'b1; arm_wd = d;
    @(negedge clk);
    arm_we = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 arm", arm_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 count", count_o, 0);
  endtask

  task automatic t_normal(int len, string req);
    wr_arm(1'b1);
    chk("R2 arm set", arm_o, 1);
    hold(1'b1, 2);
    fall_now(); hold(1'b0, 1);
    chk("R2 busy after fall", busy_o, 1);
    hold(1'b0, len - 1);
    rise_now(); hold(1'b1, 1);
    chk({req, " busy"}, busy_o, 0);
    chk({req, " arm self-clear"}, arm_o, 0);
    chk({req, " irq"}, irq_o, 1);
    chk({req, " count"}, count_o, (t1 - t0 > CMAX) ? CMAX : t1 - t0);
    clr_irq();
    chk("R9 irq cleared", irq_o, 0);
  endtask

  task automatic t_abnormal();
    int prev;
    prev = count_o;
    wr_arm(1'b1);
    fall_now(); hold(1'b0, 5);
    wr_arm(1'b0);
    hold(1'b0, 3);
    hold(1'b1, 1);
    chk("R6 irq on rise", irq_o, 1);
    chk("R6 still busy", busy_o, 1);
    chk("R6 count held", count_o, prev);
    hold(1'b1, 3);
    clr_irq();
    chk("R9 clear while abnormal", irq_o, 0);
    hold(1'b0, 4);
    chk("R7 fall while busy keeps busy", busy_o, 1);
    hold(1'b1, 1);
    chk("R6 irq on second rise", irq_o, 1);
    chk("R6 count held again", count_o, prev);
    clr_irq();
    wr_arm(1'b1);
    hold(1'b0, 6);
    rise_now(); hold(1'b1, 1);
    chk("R7 busy done", busy_o, 0);
    chk("R7 arm self-clear", arm_o, 0);
    chk("R7 irq", irq_o, 1);
    chk("R7 count from first fall", count_o, t1 - t0);
    clr_irq();
  endtask

  task automatic t_ignore();
    int prev;
    prev = count_o;
    hold(1'b0, 4); hold(1'b1, 2);
    chk("R8 disarmed busy", busy_o, 0);
    chk("R8 disarmed irq", irq_o, 0);
    wr_arm(1'b1); wr_arm(1'b0);
    hold(1'b0, 5); hold(1'b1, 2);
    chk("R8 arm-disarm busy", busy_o, 0);
    chk("R8 arm-disarm irq", irq_o, 0);
    chk("R8 count unchanged", count_o, prev);
  endtask

  task automatic t_clear_collide();
    wr_arm(1'b1);
    hold(1'b1, 1);
    fall_now(); hold(1'b0, 7);
    rise_now(); irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 set beats clear", irq_o, 1);
    chk("R3 count at collide", count_o, t1 - t0);
    clr_irq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal(12, "R3");
    t_normal(3, "R4");
    t_normal(1, "R3 one-cycle");
    t_normal(CMAX + 9, "R5");
    t_normal(20, "R4 after saturate");
    t_ignore();
    t_abnormal();
    t_clear_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule